// File: doc/BRIEF.md
# Two-State Punctured Trellis SISO Decoder

This block is the soft-in/soft-out unit for the parity-check-plus-accumulator half of an iterative, turbo-style decoder for LDPC codes whose parity section is partly dual-diagonal. The parity checks are split into groups of edges; the group sizes are set by a parameter and default to 3, 2, 3, 2, 2, 3, which gives 15 edges. The XOR of each group drives a running accumulator, and each accumulator output is a parity bit with its own channel observation. The decoder treats this chain as a two-state trellis that starts and ends in state zero. It returns one extrinsic LLR for every edge, so that the repetition decoder on the far side of the interleaver can use it.

A block of data arrives on one valid/ready input stream, one LLR per beat, in trellis order. The edges of group 0 come first, then the channel LLR of group 0's accumulator output, then group 1's edges, and so on. The last group has no parity beat, because its accumulator output is known to be zero. The forward recursion runs while the data streams in. The backward pass then sends out the extrinsics on a valid/ready output stream, from the highest edge index down to edge 0. A one-cycle `done` pulse marks the end of the block, and the next block may start at once.

All LLRs are 6-bit two's complement. A positive value means bit 0 is more likely. State metrics are kept as 9-bit differences between state 0 and state 1, which keeps them normalized at every step.

Top module: `punct_trellis_siso`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: The input phase accepts exactly W+G-1 beats (W edges, G groups) in trellis order: each group's edges, then that group's parity LLR, with no parity beat after the last group. `out_valid` stays 0 while input is being accepted, and `in_ready` is 0 while output is pending.
- R3: The W extrinsics come out in reverse edge order. `out_edge` equals W-1 on the first output beat and falls by one on each accepted beat.
- R4: An edge's extrinsic never depends on that edge's own input LLR, whether magnitude or sign. It equals minsum(E_g, others) saturated to ±31. Here minsum(a,b) has magnitude min(|a|,|b|) and is negative exactly when one of a, b is negative. "others" is the minsum over the other edges of the same group, and E_g = minsum(A_{g-1}, B_g + P_g).
- R5: Forward metric: A before group 0 is +255, which means state zero is certain. Then A_g = sat255(minsum(A_{g-1}, U_g) + P_g), where U_g is the minsum of all the edges of group g and P_g is that group's parity LLR.
- R6: Backward metric: B for the last group is +255 and P for the last group is 0. Going back, B_{g-1} = minsum(B_g + P_g, U_g).
- R7: In every minsum, a zero value counts as non-negative, and a zero magnitude gives a zero result.
- R8: Extrinsics saturate to [-31, +31]. The code -32 is accepted on input but is never produced on output.
- R9: Backpressure: while `out_valid` is 1 and `out_ready` is 0, `out_llr` and `out_edge` hold steady. On the input side, a beat transfers only on a cycle where `in_valid` and `in_ready` are both 1.
- R10: `done` is high for exactly one cycle, the cycle after the last output beat is accepted. In that cycle `in_ready` is 0, and it returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_llr | input | 6 | Edge or parity LLR, in trellis order |
| out_valid | output | 1 | Extrinsic beat valid |
| out_ready | input | 1 | Downstream accepts the extrinsic beat |
| out_llr | output | 6 | Extrinsic LLR for `out_edge` |
| out_edge | output | 4 | Edge index of the current extrinsic |
| done | output | 1 | One-cycle pulse after the last extrinsic |

## Verification
Each block of inputs is compared against a plain per-edge model that takes the minimum over the other edges by brute force. One strongly signed mixed pattern checks the forward and backward metric chaining, including the zero-state boundaries at both ends. A second pattern is dense with zeros and negative values, which separates a correct sign rule from a sign-magnitude slip. An all-extreme block (every input -32 or +31) exposes missing output saturation. A pair of blocks that differ only in one edge's magnitude and sign shows that the edge's own input is excluded. The same pattern is also run with input gaps and output stalls, to check that backpressure changes neither the values nor their order.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  localparam int LLR_W = 6;
  localparam int MET_W = 9;
  localparam int MET_MAX = 255;
  localparam int OUT_MAX = 31;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic signed [MET_W-1:0] met_t;

  localparam met_t MET_INF = met_t'(MET_MAX);

  // sign-extend a channel/edge LLR into the metric width
  function automatic met_t widen(llr_t x);
    return {{(MET_W-LLR_W){x[LLR_W-1]}}, x};
  endfunction

  // max-log combination of two parity LLRs (zero counts as non-negative)
  function automatic met_t ms(met_t a, met_t b);
    met_t ma, mb, m;
    ma = a[MET_W-1] ? -a : a;
    mb = b[MET_W-1] ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return (a[MET_W-1] ^ b[MET_W-1]) ? -m : m;
  endfunction

  // saturating metric add, symmetric range
  function automatic met_t add_m(met_t a, met_t b);
    logic signed [MET_W:0] s;
    s = {a[MET_W-1], a} + {b[MET_W-1], b};
    if (s > MET_MAX)       return MET_INF;
    else if (s < -MET_MAX) return -MET_INF;
    else                   return s[MET_W-1:0];
  endfunction

  function automatic llr_t to_out(met_t x);
    if (x > OUT_MAX)       return llr_t'(OUT_MAX);
    else if (x < -OUT_MAX) return -llr_t'(OUT_MAX);
    else                   return x[LLR_W-1:0];
  endfunction

  // sum of n packed unsigned fields of width fw
  function automatic int sum_fields(logic [63:0] v, int n, int fw);
    int s;
    s = 0;
    for (int i = 0; i < n; i++) s += int'((v >> (i*fw)) & ((64'd1 << fw) - 64'd1));
    return s;
  endfunction
endpackage

// File: rtl/tsd_grp_min.sv
module tsd_grp_min
  import tsd_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          first,
  input  logic [PW-1:0] pos,
  input  llr_t          llr,
  output met_t          min1,
  output met_t          min2,
  output logic [PW-1:0] idx,
  output logic          neg
);
  met_t wv, mag;
  always_comb begin
    wv  = widen(llr);
    mag = wv[MET_W-1] ? -wv : wv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min1 <= MET_INF;
      min2 <= MET_INF;
      idx  <= '0;
      neg  <= 1'b0;
    end else if (en) begin
      if (first) begin
        min1 <= mag;
        min2 <= MET_INF;
        idx  <= pos;
        neg  <= llr[LLR_W-1];
      end else begin
        neg <= neg ^ llr[LLR_W-1];
        if (mag < min1) begin
          min2 <= min1;
          min1 <= mag;
          idx  <= pos;
        end else if (mag < min2) begin
          min2 <= mag;
        end
      end
    end
  end

  // smallest and second-smallest magnitudes stay ordered (R4 exclusion relies on it)
  p_min_order_r4: assert property (@(posedge clk) disable iff (!rst_n) min1 <= min2);
endmodule

// File: rtl/tsd_llr_store.sv
module tsd_llr_store
  import tsd_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  llr_t          wdata,
  input  logic [AW-1:0] raddr,
  output llr_t          rdata
);
  llr_t mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/tsd_ext_unit.sv
module tsd_ext_unit
  import tsd_pkg::*;
#(
  parameter int PW = 4
) (
  input  met_t          a_prev,
  input  met_t          b_cur,
  input  met_t          lp,
  input  met_t          gm1,
  input  met_t          gm2,
  input  logic [PW-1:0] gidx,
  input  logic          gneg,
  input  llr_t          edge_llr,
  input  logic [PW-1:0] epos,
  output llr_t          ext,
  output met_t          b_next
);
  met_t c, leu, om, oth, lu;
  always_comb begin
    c      = add_m(b_cur, lp);
    leu    = ms(a_prev, c);
    om     = (epos == gidx) ? gm2 : gm1;
    oth    = (gneg ^ edge_llr[LLR_W-1]) ? -om : om;
    ext    = to_out(ms(leu, oth));
    lu     = gneg ? -gm1 : gm1;
    b_next = ms(c, lu);
  end
endmodule

// File: rtl/punct_trellis_siso.sv
module punct_trellis_siso
  import tsd_pkg::*;
#(
  parameter int NGRP = 6,
  parameter int SZW  = 4,
  parameter logic [NGRP*SZW-1:0] GSZ = {4'd3, 4'd2, 4'd2, 4'd3, 4'd2, 4'd3},
  localparam int W  = sum_fields(64'(GSZ), NGRP, SZW),
  localparam int AW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [5:0]    in_llr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [5:0]    out_llr,
  output logic [AW-1:0] out_edge,
  output logic          done
);
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

  function automatic logic [SZW-1:0] gsz(logic [GW-1:0] g);
    return GSZ[int'(g)*SZW +: SZW];
  endfunction

  typedef enum logic [1:0] {ST_IN, ST_FIN, ST_OUT, ST_DONE} st_t;

  st_t            st;
  logic [GW-1:0]  grp;
  logic [SZW-1:0] epos;
  logic [AW-1:0]  ea;
  logic           par_ph;
  met_t           a_run, b_run;

  // per-group record captured at the end of the forward pass
  met_t           g_aprev [NGRP];
  met_t           g_lp    [NGRP];
  met_t           g_m1    [NGRP];
  met_t           g_m2    [NGRP];
  logic [SZW-1:0] g_idx   [NGRP];
  logic           g_neg   [NGRP];

  met_t           t_m1, t_m2, lu_cur, a_next, b_next;
  logic [SZW-1:0] t_idx;
  logic           t_neg;
  llr_t           rd_llr, ext;

  logic in_fire, edge_fire, par_fire, out_fire, fin_grp, last_in_grp;

  assign in_ready    = (st == ST_IN);
  assign out_valid   = (st == ST_OUT);
  assign done        = (st == ST_DONE);
  assign in_fire     = in_valid && in_ready;
  assign edge_fire   = in_fire && !par_ph;
  assign par_fire    = in_fire && par_ph;
  assign out_fire    = out_valid && out_ready;
  assign fin_grp     = par_fire || (st == ST_FIN);
  assign last_in_grp = (epos == gsz(grp) - 1'b1);

  tsd_grp_min #(.PW(SZW)) i_grp_min (
    .clk(clk), .rst_n(rst_n), .en(edge_fire), .first(epos == '0), .pos(epos),
    .llr(llr_t'(in_llr)), .min1(t_m1), .min2(t_m2), .idx(t_idx), .neg(t_neg)
  );

  tsd_llr_store #(.DEPTH(W), .AW(AW)) i_store (
    .clk(clk), .we(edge_fire), .waddr(ea), .wdata(llr_t'(in_llr)),
    .raddr(ea), .rdata(rd_llr)
  );

  tsd_ext_unit #(.PW(SZW)) i_ext (
    .a_prev(g_aprev[grp]), .b_cur(b_run), .lp(g_lp[grp]),
    .gm1(g_m1[grp]), .gm2(g_m2[grp]), .gidx(g_idx[grp]), .gneg(g_neg[grp]),
    .edge_llr(rd_llr), .epos(epos), .ext(ext), .b_next(b_next)
  );

  always_comb begin
    lu_cur = t_neg ? -t_m1 : t_m1;
    a_next = add_m(ms(a_run, lu_cur), widen(llr_t'(in_llr)));
  end

  assign out_llr  = ext;
  assign out_edge = ea;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NGRP; i++) begin
        g_aprev[i] <= '0; g_lp[i] <= '0; g_m1[i] <= '0;
        g_m2[i] <= '0; g_idx[i] <= '0; g_neg[i] <= 1'b0;
      end
    end else if (fin_grp) begin
      g_aprev[grp] <= a_run;
      g_lp[grp]    <= (st == ST_FIN) ? met_t'(0) : widen(llr_t'(in_llr));
      g_m1[grp]    <= t_m1;
      g_m2[grp]    <= t_m2;
      g_idx[grp]   <= t_idx;
      g_neg[grp]   <= t_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IN; grp <= '0; epos <= '0; ea <= '0; par_ph <= 1'b0;
      a_run <= MET_INF; b_run <= MET_INF;
    end else begin
      case (st)
        ST_IN: begin
          if (edge_fire) begin
            ea <= ea + 1'b1;
            if (last_in_grp) begin
              epos <= '0;
              if (grp == GW'(NGRP-1)) st <= ST_FIN;
              else                     par_ph <= 1'b1;
            end else begin
              epos <= epos + 1'b1;
            end
          end
          if (par_fire) begin
            a_run  <= a_next;
            grp    <= grp + 1'b1;
            par_ph <= 1'b0;
          end
        end
        ST_FIN: begin
          st    <= ST_OUT;
          b_run <= MET_INF;
          ea    <= AW'(W-1);
          epos  <= gsz(grp) - 1'b1;
        end
        ST_OUT: begin
          if (out_fire) begin
            ea <= ea - 1'b1;
            if (epos == '0) begin
              b_run <= b_next;
              if (grp == '0) st <= ST_DONE;
              else begin
                grp  <= grp - 1'b1;
                epos <= gsz(grp - 1'b1) - 1'b1;
              end
            end else begin
              epos <= epos - 1'b1;
            end
          end
        end
        default: begin
          st <= ST_IN; grp <= '0; epos <= '0; ea <= '0; par_ph <= 1'b0;
          a_run <= MET_INF;
        end
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_llr) && $stable(out_edge)));
  p_first_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_edge == AW'(W-1)));
  p_edge_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_edge != '0) |=> (out_valid && out_edge == $past(out_edge) - 1'b1));
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_edge == '0) |=> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));
  p_ext_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_llr != 6'b100000));
endmodule

// File: tb/test_punct_trellis_siso.sv
`timescale 1ns/1ps
module test_punct_trellis_siso;
  localparam int W = 15;
  localparam int G = 6;
  int gs [G] = '{3, 2, 3, 2, 2, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [5:0] in_llr = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [5:0] out_llr;
  logic [3:0] out_edge;
  logic done;

  always #2.5 clk = ~clk;

  punct_trellis_siso i_punct_trellis_siso (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .out_valid(out_valid), .out_ready(out_ready),
    .out_llr(out_llr), .out_edge(out_edge), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ev [W];
  int pv [G-1];
  int exp_ext [W];
  int got [W];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction
  function automatic int msi(int a, int b);
    int m;
    m = (iabs(a) < iabs(b)) ? iabs(a) : iabs(b);
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction
  function automatic int sati(int x, int lim);
    return (x > lim) ? lim : ((x < -lim) ? -lim : x);
  endfunction

  // reference: brute-force exclusion per edge, metric chain from R5/R6
  task automatic model();
    int ap [G]; int lu [G]; int gb [G]; int base; int b; int c; int leu; int oth; int lp;
    base = 0;
    ap[0] = 255;
    for (int i = 0; i < G; i++) begin
      gb[i] = base;
      lu[i] = 255;
      for (int j = 0; j < gs[i]; j++) lu[i] = msi(lu[i], ev[base+j]);
      if (i < G-1) ap[i+1] = sati(msi(ap[i], lu[i]) + pv[i], 255);
      base += gs[i];
    end
    b = 255;
    for (int i = G-1; i >= 0; i--) begin
      lp  = (i < G-1) ? pv[i] : 0;
      c   = sati(b + lp, 255);
      leu = msi(ap[i], c);
      for (int j = 0; j < gs[i]; j++) begin
        oth = 255;
        for (int f = 0; f < gs[i]; f++) if (f != j) oth = msi(oth, ev[gb[i]+f]);
        exp_ext[gb[i]+j] = sati(msi(leu, oth), 31);
      end
      b = msi(c, lu[i]);
    end
  endtask

  task automatic send(bit gaps);
    int items [W+G-1];
    int n; int e;
    n = 0; e = 0;
    for (int i = 0; i < G; i++) begin
      for (int j = 0; j < gs[i]; j++) begin items[n] = ev[e]; n++; e++; end
      if (i < G-1) begin items[n] = pv[i]; n++; end
    end
    for (int k = 0; k < W+G-1; k++) begin
      if (gaps && (k % 3 == 1)) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "out_valid during input", int'(out_valid), 0);
      in_valid = 1'b1;
      in_llr = 6'(items[k]);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(bit stalls);
    int k; int cyc; bit held; int hv; int he;
    k = 0; cyc = 0; held = 1'b0; hv = 0; he = 0;
    while (k < W) begin
      @(negedge clk);
      cyc++;
      out_ready = stalls ? ((cyc % 3) != 0) : 1'b1;
      if (held) begin
        chk(out_llr == 6'(hv) && out_edge == 4'(he), "R9", "held beat changed",
            int'(out_llr), hv);
        held = 1'b0;
      end
      if (out_valid) begin
        chk(in_ready == 1'b0, "R2", "in_ready during output", int'(in_ready), 0);
        if (out_ready) begin
          chk(int'(out_edge) == W-1-k, "R3", "edge order", int'(out_edge), W-1-k);
          got[W-1-k] = int'(out_llr);
          k++;
        end else begin
          held = 1'b1; hv = int'(out_llr); he = int'(out_edge);
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(done == 1'b1, "R10", "done after last beat", int'(done), 1);
    chk(in_ready == 1'b0, "R10", "in_ready during done", int'(in_ready), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
    chk(in_ready == 1'b1, "R10", "in_ready after done", int'(in_ready), 1);
  endtask

  task automatic run_block(string tag, bit gaps, bit stalls);
    model();
    fork
      send(gaps);
      recv(stalls);
    join
    for (int e = 0; e < W; e++)
      chk(got[e] == exp_ext[e], tag, $sformatf("extrinsic edge %0d", e), got[e], exp_ext[e]);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_basic();
    ev = '{10, 12, -7, 9, 15, -4, 20, 6, 11, -13, 8, 3, 14, -9, 17};
    pv = '{5, -6, 12, 2, -10};
    run_block("R4 R5 R6 basic", 1'b0, 1'b0);
  endtask

  task automatic t_signs();
    ev = '{0, 5, -3, -2, -2, 7, 0, -1, -6, 4, 1, -1, 0, 0, 9};
    pv = '{0, -3, 8, -1, 4};
    run_block("R7 signs", 1'b0, 1'b0);
  endtask

  task automatic t_extremes();
    for (int e = 0; e < W; e++) ev[e] = -32;
    pv = '{31, 31, -32, 31, 31};
    run_block("R8 saturation", 1'b0, 1'b0);
    for (int e = 0; e < W; e++)
      chk(got[e] != -32, "R8", "output code -32", got[e], -31);
  endtask

  task automatic t_backpressure();
    ev = '{-11, 4, 25, 7, -7, 30, -2, 18, 5, 5, -19, 22, 3, 16, -8};
    pv = '{-9, 14, 1, -20, 6};
    run_block("R9 backpressure", 1'b1, 1'b1);
  endtask

  task automatic t_own_excluded();
    int ref5;
    ev = '{9, -14, 6, 12, -5, 20, 6, -3, 10, 8, -4, 13, 7, 11, -6};
    pv = '{4, 7, -2, 9, -5};
    run_block("R4 own-a", 1'b0, 1'b0);
    ref5 = got[5];
    ev[5] = 30;
    run_block("R4 own-b", 1'b0, 1'b0);
    chk(got[5] == ref5, "R4", "own magnitude leaks", got[5], ref5);
    ev[5] = -30;
    run_block("R4 own-c", 1'b0, 1'b0);
    chk(got[5] == ref5, "R4", "own sign leaks", got[5], ref5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_signs();
    t_extremes();
    t_backpressure();
    t_own_excluded();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule